// File: doc/BRIEF.md
# Memory-Mapped Character Output Port

This block connects a processor's 16-bit memory-mapped bus to a character display. Software sees two words. One is a status word that carries a ready flag and an interrupt-enable flag. The other is a data word that takes the next character. When software stores a character while the display is free, the block hands the low byte to the display with a one-cycle strobe. It then marks itself busy until the display answers with a completion pulse.

A store to the data word while the display is still busy is dropped, with no queue and no error. For this reason, software either polls the ready flag before each store or enables the interrupt request. The request is asserted whenever the port is ready and the enable flag is set. Reads are combinational on the address. An address the block does not decode reads as zero.

Top module: `mmio_char_out`

## Requirements
- R1: After reset the ready flag is 1, the enable flag is 0, `irq` and `chr_valid` are 0, the status word reads 0x8000 and the data word reads 0x0000.
- R2: The status word is at address 0xFE04, with ready in bit 15, enable in bit 14 and bits 13..0 reading 0. The data word is at 0xFE06. Any other address reads 0x0000.
- R3: A write to 0xFE06 while ready is 1 is accepted. On the next clock edge the ready flag drops to 0, `chr_data` takes write bits 7..0, and `chr_valid` is 1 for exactly that one cycle.
- R4: A write to 0xFE06 while ready is 0 is ignored. No `chr_valid` pulse follows, and `chr_data` and the data word keep the previously accepted character.
- R5: A `chr_done` pulse while busy sets the ready flag to 1 on the next edge.
- R6: A write to 0xFE04 loads the enable flag from write bit 14 and changes nothing else. In particular, write bit 15 never changes the ready flag.
- R7: `irq` is 1 exactly when the ready flag and the enable flag are both 1.
- R8: A read of the data word returns the last accepted character in bits 7..0, with bits 15..8 reading 0.
- R9: Writes to addresses other than 0xFE04 and 0xFE06 change no state and produce no `chr_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Word address on the processor bus |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address, zero when not decoded |
| chr_data | output | 8 | Character presented to the display |
| chr_valid | output | 1 | One-cycle strobe marking a new character |
| chr_done | input | 1 | Pulse from the display when the character is consumed |
| irq | output | 1 | Interrupt request: ready and enabled |

## Verification
The assertions assume that the display raises `chr_done` only while the port is busy, so a completion pulse never coincides with an accepted store. The bench keeps to this by pulsing `chr_done` only after a character has been sent. Write data is taken as meaningful only in the cycle where `bus_we` is high. The bench sweeps all 256 character codes and both settings of the enable flag. It sets junk in the status bits that cannot be written and in the upper data bits, to show they are masked.

// File: rtl/mmio_char_pkg.sv
package mmio_char_pkg;

  // Which of the block's words the current bus address selects.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  // Ready-flag update: an accepted store clears it, a completion sets it,
  // and the store wins when both appear together.
  function automatic logic next_ready(input logic rdy, input logic take,
                                      input logic done);
    logic n;
    n = rdy;
    if (take)      n = 1'b0;
    else if (done) n = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/mmio_char_decode.sv
module mmio_char_decode
  import mmio_char_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output reg_sel_e          sel,
  output logic              stat_wr,
  output logic              data_wr
);

  always_comb begin
    sel = SEL_NONE;
    if (addr == STAT_ADDR)      sel = SEL_STAT;
    else if (addr == DATA_ADDR) sel = SEL_DATA;
  end

  assign stat_wr = we && (sel == SEL_STAT);
  assign data_wr = we && (sel == SEL_DATA);

endmodule

// File: rtl/mmio_char_ctrl.sv
module mmio_char_ctrl
  import mmio_char_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic data_wr,
  input  logic stat_wr,
  input  logic ie_wbit,
  input  logic dev_done,
  output logic rdy,
  output logic ie,
  output logic accept,
  output logic send
);

  // A store counts only while the display is free; otherwise it is dropped.
  assign accept = data_wr && rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy  <= 1'b1;
      ie   <= 1'b0;
      send <= 1'b0;
    end else begin
      rdy  <= next_ready(rdy, accept, dev_done);
      send <= accept;
      if (stat_wr) ie <= ie_wbit;
    end
  end

endmodule

// File: rtl/mmio_char_store.sv
module mmio_char_store #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] din,
  output logic [CHAR_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

endmodule

// File: rtl/mmio_char_out.sv
module mmio_char_out
  import mmio_char_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter int                CHAR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CHAR_W-1:0] chr_data,
  output logic              chr_valid,
  input  logic              chr_done,
  output logic              irq
);

  localparam int RDY_BIT = DATA_W - 1;
  localparam int IE_BIT  = DATA_W - 2;

  reg_sel_e          sel;
  logic              stat_wr;
  logic              data_wr;
  logic              rdy_q;
  logic              ie_q;
  logic              wr_accept;
  logic              send_q;
  logic [CHAR_W-1:0] char_q;
  logic              unused_wbits;

  // Bits of the write word other than the enable bit and the character byte
  // have no effect.
  assign unused_wbits = ^bus_wdata;

  function automatic logic [DATA_W-1:0] status_word(input logic r,
                                                    input logic e);
    logic [DATA_W-1:0] w;
    w          = '0;
    w[RDY_BIT] = r;
    w[IE_BIT]  = e;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] char_word(input logic [CHAR_W-1:0] c);
    logic [DATA_W-1:0] w;
    w             = '0;
    w[CHAR_W-1:0] = c;
    return w;
  endfunction

  mmio_char_decode #(
    .ADDR_W   (ADDR_W),
    .STAT_ADDR(STAT_ADDR),
    .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .addr   (bus_addr),
    .we     (bus_we),
    .sel    (sel),
    .stat_wr(stat_wr),
    .data_wr(data_wr)
  );

  mmio_char_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_wr (data_wr),
    .stat_wr (stat_wr),
    .ie_wbit (bus_wdata[IE_BIT]),
    .dev_done(chr_done),
    .rdy     (rdy_q),
    .ie      (ie_q),
    .accept  (wr_accept),
    .send    (send_q)
  );

  mmio_char_store #(
    .CHAR_W(CHAR_W)
  ) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .load (wr_accept),
    .din  (bus_wdata[CHAR_W-1:0]),
    .q    (char_q)
  );

  always_comb begin
    case (sel)
      SEL_STAT: bus_rdata = status_word(rdy_q, ie_q);
      SEL_DATA: bus_rdata = char_word(char_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign chr_data  = char_q;
  assign chr_valid = send_q;
  assign irq       = rdy_q & ie_q;

endmodule

// File: rtl/mmio_char_out_chk.sv
module mmio_char_out_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter int                CHAR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CHAR_W-1:0] chr_data,
  input logic              chr_valid,
  input logic              chr_done,
  input logic              irq,
  input logic              rdy,
  input logic              ie,
  input logic              accept
);

  p_status_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STAT_ADDR) |-> (bus_rdata[DATA_W-3:0] == '0));

  p_accept_sends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (chr_valid && !rdy && chr_data == $past(bus_wdata[CHAR_W-1:0])));

  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |=> !chr_valid);

  p_busy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == DATA_ADDR && !rdy) |=> (!chr_valid && $stable(chr_data)));

  p_done_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && !accept) |=> rdy);

  p_stat_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == STAT_ADDR && !chr_done) |=>
      (ie == $past(bus_wdata[DATA_W-2]) && $stable(rdy)));

  p_irq_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STAT_ADDR) |-> (irq == (bus_rdata[DATA_W-1] && bus_rdata[DATA_W-2])));

  p_data_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == DATA_ADDR) |->
      (bus_rdata[DATA_W-1:CHAR_W] == '0 && bus_rdata[CHAR_W-1:0] == chr_data));

endmodule

bind mmio_char_out mmio_char_out_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CHAR_W   (CHAR_W),
  .STAT_ADDR(STAT_ADDR),
  .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .chr_data (chr_data),
  .chr_valid(chr_valid),
  .chr_done (chr_done),
  .irq      (irq),
  .rdy      (rdy_q),
  .ie       (ie_q),
  .accept   (wr_accept)
);

// File: tb/tb_mmio_char_out.sv
`timescale 1ns/1ps
module tb_mmio_char_out;

  localparam logic [15:0] A_STAT = 16'hFE04;
  localparam logic [15:0] A_DATA = 16'hFE06;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  chr_data;
  logic        chr_valid;
  logic        chr_done = 1'b0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mmio_char_out dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .chr_data (chr_data),
    .chr_valid(chr_valid),
    .chr_done (chr_done),
    .irq      (irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Store: inputs set at a falling edge, latched at the rising edge,
  // registered outputs visible at the following falling edge.
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_we    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_addr  = 16'h0000;
    #1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_pulse();
    @(negedge clk);
    chr_done = 1'b1;
    @(negedge clk);
    chr_done = 1'b0;
  endtask

  function automatic logic [15:0] stat_of(input logic r, input logic e);
    return {r, e, 14'd0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_STAT, v); chk("R1 status", v, 16'h8000);
    rd(A_DATA, v); chk("R1 data", v, 16'h0000);
    chk("R1 valid", {15'd0, chr_valid}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    for (int c = 0; c < 256; c++) begin
      logic [7:0] ch;
      logic       e;
      ch = 8'(c);
      e  = ch[1];

      // R6: junk in bit 15 and low bits, only bit 14 matters
      wr(A_STAT, {ch[0], e, ~ch[5:0], ch});
      rd(A_STAT, v); chk("R6 status after write", v, stat_of(1'b1, e));
      chk("R7 irq ready", {15'd0, irq}, {15'd0, e});

      // R3 accepted store
      wr(A_DATA, {~ch, ch});
      chk("R3 valid", {15'd0, chr_valid}, 16'd1);
      chk("R3 char", {8'd0, chr_data}, {8'd0, ch});
      rd(A_STAT, v);
      chk("R3 valid one cycle", {15'd0, chr_valid}, 16'd0);
      chk("R3 ready cleared", v, stat_of(1'b0, e));
      chk("R7 irq busy", {15'd0, irq}, 16'd0);

      // R4 store while busy
      wr(A_DATA, {ch, ~ch});
      chk("R4 no valid", {15'd0, chr_valid}, 16'd0);
      chk("R4 char kept", {8'd0, chr_data}, {8'd0, ch});
      rd(A_DATA, v); chk("R8 data readback", v, {8'd0, ch});

      // R5 completion
      finish_pulse();
      rd(A_STAT, v); chk("R5 ready set", v, stat_of(1'b1, e));
      chk("R7 irq after done", {15'd0, irq}, {15'd0, e});

      // R9 / R2 other addresses
      if ((c % 16) == 3) begin
        wr(16'hFE05, 16'hFFFF);
        chk("R9 no valid", {15'd0, chr_valid}, 16'd0);
        wr(16'hFE02, 16'h00AA);
        rd(16'hFE05, v); chk("R2 undecoded read", v, 16'h0000);
        rd(A_DATA, v);   chk("R9 data kept", v, {8'd0, ch});
        rd(A_STAT, v);   chk("R9 status kept", v, stat_of(1'b1, e));
      end
    end

    // R6 bit 15 cannot set ready while busy
    wr(A_STAT, 16'h0000);
    wr(A_DATA, 16'h0041);
    wr(A_STAT, 16'hC000);
    rd(A_STAT, v); chk("R6 ready not writable", v, 16'h4000);
    chk("R7 irq busy enabled", {15'd0, irq}, 16'd0);
    finish_pulse();
    rd(A_STAT, v); chk("R5 ready after done", v, 16'hC000);
    chk("R7 irq raised", {15'd0, irq}, 16'd1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule